// File: doc/BRIEF.md
# Windowed Display RAM Address Generator

This block holds the column and row pointers that a display controller uses when the host reads or writes pixel memory. The host defines a rectangular window by loading a start and an end value for each axis. Each completed RAM access advances the pointers so that consecutive bytes fill the window, either row by row or column by column. Both pointers stay inside the window indefinitely.

Two remapping options sit at the outputs. A mirror bit turns the logical column into its right-to-left counterpart before it reaches the RAM. A swap bit exchanges the upper and lower halves of each data byte, on the write path and on the read path alike. The pixel array and the panel refresh scan are outside this block.

Top module: `win_addr_gen`

## Requirements
- R1: A pulse on `col_load` stores `col_start`/`col_end` as the column window and sets the column pointer to `col_start` on the next clock.
- R2: A pulse on `row_load` stores `row_start`/`row_end` as the row window and sets the row pointer to `row_start` on the next clock.
- R3: With `vert_mode` = 0, every `access` pulse advances the column by one. An access that finds the column at its window end returns it to the column start and advances the row.
- R4: With `vert_mode` = 1, every `access` pulse advances the row by one. An access that finds the row at its window end returns it to the row start and advances the column.
- R5: A row advance that finds the row at its window end returns it to the row start.
- R6: A column advance that finds the column at its window end returns it to the column start, in either mode.
- R7: When a window start is above its end, the pointer counts up through the all-ones value, wraps to zero and continues up to the end before it returns to the start.
- R8: With `col_mirror` = 1, `ram_col` equals 63 minus the logical column (default 6-bit column). With `col_mirror` = 0, `ram_col` equals the logical column. The pointer sequence does not depend on this bit.
- R9: With `nib_swap` = 1, bits [7:4] and [3:0] are exchanged from `host_wdata` to `ram_wdata` and from `ram_rdata` to `host_rdata`. With `nib_swap` = 0, both paths pass data unchanged.
- R10: After reset both pointers are 0, and the windows span the full range: columns 0 to 63 and rows 0 to 127.
- R11: In a cycle with no `access` and no load strobe, both pointers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| col_start | input | 6 | Column window start |
| col_end | input | 6 | Column window end |
| col_load | input | 1 | Load strobe for the column window |
| row_start | input | 7 | Row window start |
| row_end | input | 7 | Row window end |
| row_load | input | 1 | Load strobe for the row window |
| vert_mode | input | 1 | 0: column advances first; 1: row advances first |
| col_mirror | input | 1 | Mirror the column order right to left |
| nib_swap | input | 1 | Swap the byte halves on both data paths |
| access | input | 1 | One pulse after each RAM read or write |
| host_wdata | input | 8 | Write data from the host |
| ram_wdata | output | 8 | Write data toward the RAM |
| ram_rdata | input | 8 | Read data from the RAM |
| host_rdata | output | 8 | Read data toward the host |
| ram_col | output | 6 | Physical column address |
| ram_row | output | 7 | Physical row address |

## Verification
The checker assumes that a load strobe and an access pulse never occur in the same cycle. It also assumes that `vert_mode` holds steady across the cycle in which an access is sampled. The bench drives every strobe as a single-cycle pulse at the falling edge, with idle cycles between them. It changes the mode and remap bits only while no access is pending. Windows with a start above the end are applied on purpose to exercise the wrap through zero.

// File: rtl/wag_pkg.sv
package wag_pkg;
  localparam int COL_W_DEF  = 6;
  localparam int ROW_W_DEF  = 7;
  localparam int DATA_W_DEF = 8;

  typedef enum logic {
    INC_HORIZ = 1'b0,
    INC_VERT  = 1'b1
  } inc_mode_e;
endpackage

// File: rtl/wag_rst_sync.sv
module wag_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb shift_d = {shift_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_d;
  end

  assign rst_n_sync = shift_q[STAGES-1];
endmodule

// File: rtl/wag_axis_ptr.sv
module wag_axis_ptr #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] start_i,
  input  logic [W-1:0] end_i,
  input  logic         step,
  output logic [W-1:0] ptr_o,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] hi_o,
  output logic         at_end_o
);
  logic [W-1:0] lo_q, lo_d;
  logic [W-1:0] hi_q, hi_d;
  logic [W-1:0] ptr_q, ptr_d;
  logic         at_end;

  assign at_end = (ptr_q == hi_q);

  always_comb begin
    lo_d  = lo_q;
    hi_d  = hi_q;
    ptr_d = ptr_q;
    if (load) begin
      lo_d  = start_i;
      hi_d  = end_i;
      ptr_d = start_i;
    end else if (step) begin
      ptr_d = at_end ? lo_q : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '1;
      ptr_q <= '0;
    end else if (load || step) begin
      lo_q  <= lo_d;
      hi_q  <= hi_d;
      ptr_q <= ptr_d;
    end
  end

  assign ptr_o    = ptr_q;
  assign lo_o     = lo_q;
  assign hi_o     = hi_q;
  assign at_end_o = at_end;
endmodule

// File: rtl/wag_nibble_swap.sv
module wag_nibble_swap #(
  parameter int DATA_W = 8
) (
  input  logic              swap,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  localparam int HALF = DATA_W / 2;

  generate
    if (DATA_W % 2 == 0) begin : g_swap
      assign q = swap ? {d[HALF-1:0], d[DATA_W-1:HALF]} : d;
    end else begin : g_pass
      logic unused_swap;
      assign unused_swap = swap;
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/win_addr_gen.sv
module win_addr_gen
  import wag_pkg::*;
#(
  parameter int COL_W  = COL_W_DEF,
  parameter int ROW_W  = ROW_W_DEF,
  parameter int DATA_W = DATA_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [COL_W-1:0]  col_start,
  input  logic [COL_W-1:0]  col_end,
  input  logic              col_load,
  input  logic [ROW_W-1:0]  row_start,
  input  logic [ROW_W-1:0]  row_end,
  input  logic              row_load,
  input  logic              vert_mode,
  input  logic              col_mirror,
  input  logic              nib_swap,
  input  logic              access,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic [COL_W-1:0]  ram_col,
  output logic [ROW_W-1:0]  ram_row
);
  localparam logic [COL_W-1:0] COL_MAX = '1;

  logic             rst_n_sync;
  inc_mode_e        mode;
  logic             col_step, row_step;
  logic             col_at_end, row_at_end;
  logic [COL_W-1:0] col_ptr, col_lo, col_hi;
  logic [ROW_W-1:0] row_ptr, row_lo, row_hi;

  wag_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  assign mode     = inc_mode_e'(vert_mode);
  assign col_step = access && ((mode == INC_HORIZ) || row_at_end);
  assign row_step = access && ((mode == INC_VERT)  || col_at_end);

  wag_axis_ptr #(.W(COL_W)) u_col (
    .clk(clk), .rst_n(rst_n_sync), .load(col_load),
    .start_i(col_start), .end_i(col_end), .step(col_step),
    .ptr_o(col_ptr), .lo_o(col_lo), .hi_o(col_hi), .at_end_o(col_at_end)
  );

  wag_axis_ptr #(.W(ROW_W)) u_row (
    .clk(clk), .rst_n(rst_n_sync), .load(row_load),
    .start_i(row_start), .end_i(row_end), .step(row_step),
    .ptr_o(row_ptr), .lo_o(row_lo), .hi_o(row_hi), .at_end_o(row_at_end)
  );

  assign ram_col = col_mirror ? (COL_MAX - col_ptr) : col_ptr;
  assign ram_row = row_ptr;

  wag_nibble_swap #(.DATA_W(DATA_W)) u_wr_swap (
    .swap(nib_swap), .d(host_wdata), .q(ram_wdata)
  );

  wag_nibble_swap #(.DATA_W(DATA_W)) u_rd_swap (
    .swap(nib_swap), .d(ram_rdata), .q(host_rdata)
  );
endmodule

// File: rtl/win_addr_gen_chk.sv
module win_addr_gen_chk #(
  parameter int COL_W = 6,
  parameter int ROW_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             col_load,
  input logic             row_load,
  input logic             access,
  input logic             vert_mode,
  input logic [COL_W-1:0] col_start,
  input logic [ROW_W-1:0] row_start,
  input logic [COL_W-1:0] col_ptr,
  input logic [COL_W-1:0] col_lo,
  input logic [COL_W-1:0] col_hi,
  input logic [ROW_W-1:0] row_ptr,
  input logic [ROW_W-1:0] row_lo,
  input logic [ROW_W-1:0] row_hi
);
  logic plain_acc;
  assign plain_acc = access && !col_load && !row_load;

  AST_COL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    col_load |=> col_ptr == $past(col_start)); // R1

  AST_ROW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    row_load |=> row_ptr == $past(row_start)); // R2

  AST_HORIZ_ROW_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (plain_acc && !vert_mode) |=> (row_ptr == $past(row_ptr)) || (col_ptr == col_lo)); // R3

  AST_VERT_COL_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (plain_acc && vert_mode) |=> (col_ptr == $past(col_ptr)) || (row_ptr == row_lo)); // R4

  AST_ROW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (plain_acc && row_ptr == row_hi && (vert_mode || col_ptr == col_hi))
      |=> row_ptr == $past(row_lo)); // R5

  AST_COL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (plain_acc && col_ptr == col_hi && (!vert_mode || row_ptr == row_hi))
      |=> col_ptr == $past(col_lo)); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!access && !col_load && !row_load) |=> $stable(col_ptr) && $stable(row_ptr)); // R11
endmodule

bind win_addr_gen win_addr_gen_chk #(.COL_W(COL_W), .ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n_sync), .col_load(col_load), .row_load(row_load),
  .access(access), .vert_mode(vert_mode), .col_start(col_start),
  .row_start(row_start), .col_ptr(col_ptr), .col_lo(col_lo), .col_hi(col_hi),
  .row_ptr(row_ptr), .row_lo(row_lo), .row_hi(row_hi)
);

// File: tb/win_addr_gen_tb.sv
`timescale 1ns/1ps
module win_addr_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] col_start, col_end;
  logic       col_load;
  logic [6:0] row_start, row_end;
  logic       row_load;
  logic       vert_mode, col_mirror, nib_swap, access;
  logic [7:0] host_wdata, ram_wdata, ram_rdata, host_rdata;
  logic [5:0] ram_col;
  logic [6:0] ram_row;

  int tests = 0;
  int fails = 0;

  // reference model state
  int m_cs, m_ce, m_rs, m_re, m_c, m_r;

  always #2.5 clk = ~clk;

  win_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .col_start(col_start), .col_end(col_end),
    .col_load(col_load), .row_start(row_start), .row_end(row_end),
    .row_load(row_load), .vert_mode(vert_mode), .col_mirror(col_mirror),
    .nib_swap(nib_swap), .access(access), .host_wdata(host_wdata),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .host_rdata(host_rdata),
    .ram_col(ram_col), .ram_row(ram_row)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  function automatic int adv(input int p, input int lo, input int hi, input int mx);
    if (p == hi) return lo;
    return (p + 1) % (mx + 1);
  endfunction

  task automatic load_win(input int cs, input int ce, input int rs, input int re);
    @(negedge clk);
    col_start = 6'(cs); col_end = 6'(ce); row_start = 7'(rs); row_end = 7'(re);
    col_load = 1'b1; row_load = 1'b1;
    @(negedge clk);
    col_load = 1'b0; row_load = 1'b0;
    m_cs = cs; m_ce = ce; m_rs = rs; m_re = re; m_c = cs; m_r = rs;
  endtask

  task automatic do_access();
    bit cw, rw;
    @(negedge clk);
    access = 1'b1;
    @(negedge clk);
    access = 1'b0;
    cw = (m_c == m_ce);
    rw = (m_r == m_re);
    if (!vert_mode) begin
      m_c = adv(m_c, m_cs, m_ce, 63);
      if (cw) m_r = adv(m_r, m_rs, m_re, 127);
    end else begin
      m_r = adv(m_r, m_rs, m_re, 127);
      if (rw) m_c = adv(m_c, m_cs, m_ce, 63);
    end
  endtask

  task automatic check_pos(input string req);
    check(req, int'(ram_col), col_mirror ? 63 - m_c : m_c);
    check(req, int'(ram_row), m_r);
  endtask

  task automatic t_reset();
    check("R10 col", int'(ram_col), 0);
    check("R10 row", int'(ram_row), 0);
    m_cs = 0; m_ce = 63; m_rs = 0; m_re = 127; m_c = 0; m_r = 0;
    for (int i = 0; i < 64; i++) do_access();
    check("R10 full col window", int'(ram_col), 0);
    check("R10 full row window", int'(ram_row), 1);
  endtask

  task automatic t_horiz();
    vert_mode = 1'b0;
    load_win(2, 4, 5, 6);
    check_pos("R1 R2 load");
    for (int i = 0; i < 7; i++) begin
      do_access();
      check_pos("R3 R5 horizontal");
    end
    check("R5 row back to start", int'(ram_row), 5);
  endtask

  task automatic t_vert();
    vert_mode = 1'b1;
    load_win(10, 11, 20, 22);
    for (int i = 0; i < 7; i++) begin
      do_access();
      check_pos("R4 R6 vertical");
    end
    check("R6 col back to start", int'(ram_col), 10);
    vert_mode = 1'b0;
  endtask

  task automatic t_reverse();
    load_win(62, 1, 126, 1);
    vert_mode = 1'b0;
    for (int i = 0; i < 5; i++) begin
      do_access();
      check_pos("R7 col wrap through zero");
    end
    vert_mode = 1'b1;
    for (int i = 0; i < 6; i++) begin
      do_access();
      check_pos("R7 row wrap through zero");
    end
    vert_mode = 1'b0;
  endtask

  task automatic t_mirror();
    load_win(5, 7, 0, 3);
    col_mirror = 1'b1;
    #1 check("R8 mirror", int'(ram_col), 58);
    for (int i = 0; i < 4; i++) begin
      do_access();
      check_pos("R8 mirror sequence");
    end
    col_mirror = 1'b0;
    #1 check("R8 no mirror", int'(ram_col), m_c);
  endtask

  task automatic t_nibble();
    host_wdata = 8'hA5; ram_rdata = 8'h3C; nib_swap = 1'b0;
    #1 check("R9 pass wr", int'(ram_wdata), 8'hA5);
    check("R9 pass rd", int'(host_rdata), 8'h3C);
    nib_swap = 1'b1;
    #1 check("R9 swap wr", int'(ram_wdata), 8'h5A);
    check("R9 swap rd", int'(host_rdata), 8'hC3);
    nib_swap = 1'b0;
  endtask

  task automatic t_idle();
    load_win(8, 12, 30, 40);
    do_access();
    do_access();
    for (int i = 0; i < 5; i++) @(negedge clk);
    check_pos("R11 hold without access");
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0;
    col_start = '0; col_end = '0; row_start = '0; row_end = '0;
    col_load = 1'b0; row_load = 1'b0; vert_mode = 1'b0;
    col_mirror = 1'b0; nib_swap = 1'b0; access = 1'b0;
    host_wdata = '0; ram_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_horiz();
    t_vert();
    t_reverse();
    t_mirror();
    t_nibble();
    t_idle();
    summary();
  end
endmodule